// File: doc/BRIEF.md
# Load-Tracking Frequency Change Requester

This block watches a periodic load measurement and decides when the clock should be made faster or slower. Each valid sample moves a smoothed load average toward the new value by a programmable fraction. A 6-bit level taken from that average is compared against three programmable limits: a raise limit, a lower limit and a panic limit. The raise and lower conditions must hold for a programmed number of consecutive decided samples before a request is issued. The panic condition issues a request on the first sample that meets it.

A request stays on its output and sets an event flag until software clears the flag with a write-one-to-clear. The flag can drive an interrupt line, which can be masked. Configuration is written through a simple address/data write port with this map. Address 0 holds the control word: bit 0 enables tracking and bit 1 enables the interrupt. Address 1 holds the limits: raise in [5:0], lower in [13:8] and panic in [21:16]. Address 2 holds the repeat counts: raise in [7:0] and lower in [15:8]. Address 3 holds the smoothing weight W in [8:0], which resets to 511. Address 4 is the event-clear register, where bit 0 is the clear bit.

A three-state controller sequences the block. IDLE means tracking is disabled. TRACK means samples are being decided. HOLD means a request is pending. The controller has five transitions. IDLE goes to TRACK when the enable is set. Either IDLE or TRACK goes to HOLD when a request fires. HOLD goes to TRACK on a clear write. Any state goes to IDLE when the enable is cleared.

Top module: `load_freq_requester`

## Requirements
- R1: After reset, and whenever control bit 0 is 0, the outputs req_up, req_down, req_panic, evt_status and irq are all 0, and samples cause no request. Clearing the enable while a request is pending drops that request on the following cycle.
- R2: The smoothed average starts at 0 when tracking is enabled. On each valid sample it becomes avg + (sample − avg)·(W+1)/512, rounded down, with 9 fraction bits kept. The level is the upper 6 bits of the 8-bit integer part, so at W=511 the level equals sample>>2. The integer part after an update always lies between the old integer part and the sample.
- R3: When the level is greater than the panic limit, req_panic is set after the clock edge that takes that sample. It takes priority over a raise or lower decision, and it clears both repeat counters.
- R4: When the level is greater than the raise limit but does not meet the panic condition, the raise counter advances and the lower counter clears. req_up is set once the count reaches the raise repeat count, and a count of 0 acts as 1. Issuing req_up clears the raise counter.
- R5: When the level is below the lower limit and the raise condition does not hold, the lower counter advances and the raise counter clears. req_down is set once the count reaches the lower repeat count. When both conditions hold, the raise decision wins.
- R6: A sample that meets neither the raise nor the lower condition clears both counters.
- R7: A request stays asserted and unchanged until a write to address 4 with bit 0 set. While a request is pending, samples issue no new request and leave the counters unchanged. A write to address 4 with bit 0 clear has no effect.
- R8: evt_status is 1 exactly while a request is pending. irq equals evt_status AND control bit 1.
- R9: At most one of req_up, req_down and req_panic is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (3) | Configuration word address |
| cfg_wdata | input | DATA_W (32) | Configuration write data |
| smp_valid | input | 1 | Load sample present this cycle |
| smp_load | input | LOAD_W (8) | Load sample value |
| req_up | output | 1 | Frequency-increase request |
| req_down | output | 1 | Frequency-decrease request |
| req_panic | output | 1 | Panic frequency-increase request |
| evt_status | output | 1 | Event flag, set while a request is pending |
| irq | output | 1 | Interrupt, evt_status gated by the interrupt enable |

## Verification
The hardest state to reach from the ports is a partly filled repeat counter whose value matters. A clear can only be seen when the next sample needs a full recount. The stimulus table therefore places neutral, opposite-direction and panic samples between raise samples, and it checks that the following raise sample is not yet enough for a request. A second hard case is a smoothed average that has not settled. With W=255, two identical full-scale samples bring the level first exactly onto the panic limit and then past it, which distinguishes the weighting and the strict comparison.

// File: rtl/lfr_pkg.sv
`timescale 1ns/1ps
package lfr_pkg;
    localparam int THR_W = 6;
    localparam int CNT_W = 8;
    localparam int WGT_W = 9;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_LIMIT = 1;
    localparam int ADDR_RPT   = 2;
    localparam int ADDR_WGT   = 3;
    localparam int ADDR_EVENT = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_HOLD  = 2'd2
    } lfr_state_e;

    typedef struct packed {
        logic             track_en;
        logic             irq_en;
        logic [THR_W-1:0] up_thr;
        logic [THR_W-1:0] dn_thr;
        logic [THR_W-1:0] pnc_thr;
        logic [CNT_W-1:0] up_lim;
        logic [CNT_W-1:0] dn_lim;
        logic [WGT_W-1:0] weight;
    } lfr_cfg_t;
endpackage

// File: rtl/lfr_cfg_regs.sv
`timescale 1ns/1ps
module lfr_cfg_regs
    import lfr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output lfr_cfg_t          cfg,
    output logic              ack
);
    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata;

    assign ack = wr && (addr == ADDR_W'(ADDR_EVENT)) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg        <= '0;
            cfg.weight <= '1;
        end else if (wr) begin
            if (addr == ADDR_W'(ADDR_CTRL)) begin
                cfg.track_en <= wdata[0];
                cfg.irq_en   <= wdata[1];
            end else if (addr == ADDR_W'(ADDR_LIMIT)) begin
                cfg.up_thr  <= wdata[THR_W-1:0];
                cfg.dn_thr  <= wdata[8 +: THR_W];
                cfg.pnc_thr <= wdata[16 +: THR_W];
            end else if (addr == ADDR_W'(ADDR_RPT)) begin
                cfg.up_lim <= wdata[CNT_W-1:0];
                cfg.dn_lim <= wdata[8 +: CNT_W];
            end else if (addr == ADDR_W'(ADDR_WGT)) begin
                cfg.weight <= wdata[WGT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/lfr_smoother.sv
`timescale 1ns/1ps
module lfr_smoother
    import lfr_pkg::*;
#(
    parameter int LOAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              valid,
    input  logic [LOAD_W-1:0] load,
    input  logic [WGT_W-1:0]  weight,
    output logic [THR_W-1:0]  level_next
);
    localparam int FRAC_W = WGT_W;
    localparam int ACC_W  = LOAD_W + FRAC_W;
    localparam int DIF_W  = ACC_W + 1;
    localparam int GAN_W  = WGT_W + 2;
    localparam int PRD_W  = DIF_W + GAN_W;

    logic [ACC_W-1:0]        acc_q;
    logic [ACC_W-1:0]        acc_next;
    logic signed [DIF_W-1:0] diff;
    logic signed [GAN_W-1:0] gain;
    logic signed [PRD_W-1:0] prod;
    logic signed [PRD_W-1:0] step;
    logic signed [PRD_W-1:0] sum;
    logic                    unused_sum_bits;
    logic [LOAD_W-1:0]       acc_int;

    always_comb begin
        diff     = $signed({1'b0, load, {FRAC_W{1'b0}}}) - $signed({1'b0, acc_q});
        gain     = $signed({1'b0, {1'b0, weight} + (WGT_W+1)'(1)});
        prod     = PRD_W'(diff) * PRD_W'(gain);
        step     = prod >>> FRAC_W;
        sum      = $signed({{(PRD_W-ACC_W){1'b0}}, acc_q}) + step;
        acc_next = sum[ACC_W-1:0];
    end

    assign unused_sum_bits = ^sum[PRD_W-1:ACC_W];
    assign level_next      = acc_next[ACC_W-1 -: THR_W];
    assign acc_int         = acc_q[ACC_W-1:FRAC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (!en)    acc_q <= '0;
        else if (valid)  acc_q <= acc_next;
    end

    // R2: the average moves toward the sample and never past it
    assert_avg_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && valid) |=>
            (acc_int >= (($past(acc_int) < $past(load)) ? $past(acc_int) : $past(load))) &&
            (acc_int <= (($past(acc_int) > $past(load)) ? $past(acc_int) : $past(load))));
endmodule

// File: rtl/lfr_decider.sv
`timescale 1ns/1ps
module lfr_decider
    import lfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  lfr_cfg_t         cfg,
    input  logic             smp_valid,
    input  logic [THR_W-1:0] level,
    input  logic             ack,
    output logic             req_up,
    output logic             req_dn,
    output logic             req_pnc,
    output logic             status
);
    lfr_state_e       state_q, state_d;
    logic [CNT_W-1:0] up_cnt_q, dn_cnt_q;
    logic [CNT_W:0]   up_inc, dn_inc;
    logic             decide, pnc_cond, up_cond, dn_cond, up_hit, dn_hit, fire;

    always_comb begin
        decide   = cfg.track_en && smp_valid && (state_q != ST_HOLD);
        pnc_cond = level > cfg.pnc_thr;
        up_cond  = level > cfg.up_thr;
        dn_cond  = level < cfg.dn_thr;
        up_inc   = {1'b0, up_cnt_q} + (CNT_W+1)'(1);
        dn_inc   = {1'b0, dn_cnt_q} + (CNT_W+1)'(1);
        up_hit   = up_inc >= {1'b0, cfg.up_lim};
        dn_hit   = dn_inc >= {1'b0, cfg.dn_lim};
        fire     = decide && (pnc_cond || (up_cond && up_hit) ||
                              (!up_cond && dn_cond && dn_hit));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cfg.track_en) state_d = fire ? ST_HOLD : ST_TRACK;
            ST_TRACK: if (!cfg.track_en) state_d = ST_IDLE;
                      else if (fire)     state_d = ST_HOLD;
            ST_HOLD:  if (!cfg.track_en) state_d = ST_IDLE;
                      else if (ack)      state_d = ST_TRACK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and repeat counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {req_up, req_dn, req_pnc, status} <= '0;
            up_cnt_q <= '0;
            dn_cnt_q <= '0;
        end else if (!cfg.track_en) begin
            {req_up, req_dn, req_pnc, status} <= '0;
            up_cnt_q <= '0;
            dn_cnt_q <= '0;
        end else if (state_q == ST_HOLD) begin
            if (ack) {req_up, req_dn, req_pnc, status} <= '0;
        end else if (decide) begin
            if (pnc_cond) begin
                req_pnc  <= 1'b1;
                status   <= 1'b1;
                up_cnt_q <= '0;
                dn_cnt_q <= '0;
            end else if (up_cond) begin
                dn_cnt_q <= '0;
                if (up_hit) begin
                    req_up   <= 1'b1;
                    status   <= 1'b1;
                    up_cnt_q <= '0;
                end else begin
                    up_cnt_q <= up_inc[CNT_W-1:0];
                end
            end else if (dn_cond) begin
                up_cnt_q <= '0;
                if (dn_hit) begin
                    req_dn   <= 1'b1;
                    status   <= 1'b1;
                    dn_cnt_q <= '0;
                end else begin
                    dn_cnt_q <= dn_inc[CNT_W-1:0];
                end
            end else begin
                up_cnt_q <= '0;
                dn_cnt_q <= '0;
            end
        end
    end

    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.track_en |=> !(req_up || req_dn || req_pnc || status));

    assert_panic_needs_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_pnc) |-> $past(smp_valid) && ($past(level) > $past(cfg.pnc_thr)));

    assert_up_needs_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_up) |-> $past(smp_valid) && ($past(level) > $past(cfg.up_thr)));

    assert_pending_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !ack && cfg.track_en) |=> $stable({req_up, req_dn, req_pnc}));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && ack) |=> !(req_up || req_dn || req_pnc));

    assert_status_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status == (req_up || req_dn || req_pnc));

    assert_single_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_up, req_dn, req_pnc}));
endmodule

// File: rtl/load_freq_requester.sv
`timescale 1ns/1ps
module load_freq_requester
    import lfr_pkg::*;
#(
    parameter int LOAD_W = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              smp_valid,
    input  logic [LOAD_W-1:0] smp_load,
    output logic              req_up,
    output logic              req_down,
    output logic              req_panic,
    output logic              evt_status,
    output logic              irq
);
    lfr_cfg_t         cfg;
    logic             ack;
    logic [THR_W-1:0] level;

    lfr_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg(cfg), .ack(ack)
    );

    lfr_smoother #(.LOAD_W(LOAD_W)) u_smooth (
        .clk(clk), .rst_n(rst_n), .en(cfg.track_en), .valid(smp_valid),
        .load(smp_load), .weight(cfg.weight), .level_next(level)
    );

    lfr_decider u_decide (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .smp_valid(smp_valid),
        .level(level), .ack(ack), .req_up(req_up), .req_dn(req_down),
        .req_pnc(req_panic), .status(evt_status)
    );

    assign irq = evt_status && cfg.irq_en;

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> evt_status);
endmodule

// File: tb/test_load_freq_requester.sv
`timescale 1ns/1ps
module test_load_freq_requester;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_load = '0;
    logic        req_up, req_down, req_panic, evt_status, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    load_freq_requester i_load_freq_requester (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_load(smp_load),
        .req_up(req_up), .req_down(req_down), .req_panic(req_panic),
        .evt_status(evt_status), .irq(irq)
    );

    // {load[7:0], expected {panic, up, down}}, limits up 40 / down 10 / panic 60, repeats 2 / 3, W 511
    localparam int NVEC = 20;
    localparam logic [10:0] VEC [NVEC] = '{
        {8'd80,  3'b000}, {8'd164, 3'b000}, {8'd164, 3'b010}, {8'd164, 3'b000},
        {8'd80,  3'b000}, {8'd164, 3'b000}, {8'd20,  3'b000}, {8'd164, 3'b000},
        {8'd20,  3'b000}, {8'd20,  3'b000}, {8'd20,  3'b001}, {8'd244, 3'b100},
        {8'd160, 3'b000}, {8'd40,  3'b000}, {8'd164, 3'b000}, {8'd244, 3'b100},
        {8'd164, 3'b000}, {8'd164, 3'b010}, {8'd255, 3'b100}, {8'd36,  3'b000}
    };

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic sample(input logic [7:0] v);
        @(negedge clk);
        smp_valid = 1'b1; smp_load = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {req_panic, req_up, req_down, evt_status, irq};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {panic,up,down,status,irq} got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", 5'b00000);

        // disabled: samples have no effect (R1)
        wr_reg(3'd1, (32'd60 << 16) | (32'd10 << 8) | 32'd40);
        wr_reg(3'd2, (32'd3 << 8) | 32'd2);
        sample(8'd255);
        check("R1 disabled", 5'b00000);

        wr_reg(3'd0, 32'd3);
        @(negedge clk);

        // table walk: R3 R4 R5 R6 R8
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] e;
            e = VEC[i][2:0];
            sample(VEC[i][10:3]);
            check($sformatf("R3/R4/R5/R6 vec%0d", i), {e, |e, |e});
            if (|e) begin
                wr_reg(3'd4, 32'd1);
                check($sformatf("R7 clear vec%0d", i), 5'b00000);
            end
        end

        // R7: pending request holds, other samples ignored, clear with bit0=0 ignored
        sample(8'd164);
        sample(8'd164);
        check("R4 up after two", 5'b01011);
        sample(8'd255);
        check("R7 hold vs panic", 5'b01011);
        wr_reg(3'd4, 32'd2);
        check("R7 clear bit0=0", 5'b01011);
        wr_reg(3'd4, 32'd1);
        check("R7 clear", 5'b00000);
        sample(8'd164);
        check("R4 counter restarted", 5'b00000);

        // R8: interrupt masked
        wr_reg(3'd0, 32'd1);
        sample(8'd255);
        check("R8 irq masked", 5'b10010);
        wr_reg(3'd4, 32'd1);
        check("R8 clear", 5'b00000);

        // R5: raise wins when both hold, lower otherwise
        wr_reg(3'd0, 32'd3);
        wr_reg(3'd1, (32'd63 << 16) | (32'd40 << 8) | 32'd20);
        wr_reg(3'd2, (32'd1 << 8) | 32'd1);
        sample(8'd120);
        check("R5 up priority", 5'b01011);
        wr_reg(3'd4, 32'd1);
        sample(8'd40);
        check("R5 down", 5'b00111);
        wr_reg(3'd4, 32'd1);

        // R2: weight 255, level 31 then 47 against panic limit 31
        wr_reg(3'd0, 32'd0);
        @(negedge clk);
        wr_reg(3'd3, 32'd255);
        wr_reg(3'd1, (32'd31 << 16) | (32'd0 << 8) | 32'd63);
        wr_reg(3'd0, 32'd3);
        @(negedge clk);
        sample(8'd255);
        check("R2 first step level 31", 5'b00000);
        sample(8'd255);
        check("R2 second step level 47", 5'b10011);

        // R1: disabling drops the pending request
        wr_reg(3'd0, 32'd0);
        @(negedge clk);
        check("R1 disable clears", 5'b00000);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule